// File: doc/BRIEF.md
# Low-Power Bus Wakeup Pattern Matcher

This block recognises a remote wakeup request on a bus that is being watched by a low-power receiver. It looks at two digitised comparator outputs. One says the bus is driven dominant (Data_0). The other says the bus is recessive, meaning either Idle or Data_1. A valid request has four phases in a fixed order: a dominant phase, a recessive phase, a second dominant phase and a final recessive phase. Each phase must last at least its own cycle threshold. The whole sequence must finish inside a total time window. An interruption of a phase that is shorter than an acceptance length is ignored.

When the final phase reaches its length and the enable input is high, the block raises `wake` for exactly one clock cycle. That pulse sets the wake flag elsewhere in the chip. The matcher keeps running while the enable is low. This lets a pattern that starts before low-power mode is entered still complete once the mode is active. All durations are parameters counted in clock cycles. The defaults suit a 200 MHz clock: a 2 µs phase threshold, a 0.3 µs acceptance length and a 100 µs window.

Top module: `bus_wake_matcher`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `wake` is low; a bus held recessive after reset never raises `wake`.
- R2: The sequence dominant ≥ `D0_CYC`, recessive ≥ `IDLE_CYC`, dominant ≥ `D0_CYC`, recessive ≥ `IDLE_CYC` produces `wake` high for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the `IDLE_CYC`-th cycle of the final recessive phase.
- R3: If a dominant phase or the separating recessive phase is shorter than its threshold when the opposite level has persisted for `INT_CYC` cycles, the attempt is dropped and matching restarts from search.
- R4: Fewer than `INT_CYC` consecutive non-matching cycles inside a phase do not end it. Once `INT_CYC` such cycles have passed, a qualified phase hands over to the next one, and those `INT_CYC` cycles are credited to the new phase.
- R5: A pattern counts only if it completes within `WIN_CYC` cycles, counted from its first dominant cycle. If it reaches that count first, it is abandoned and matching restarts from search.
- R6: `wake` can go high only if `en` was high at the clock edge that completes the pattern. A pattern that completes while `en` is low produces no pulse.
- R7: Matching does not depend on `en`. A pattern whose earlier phases occur while `en` is low and which completes after `en` has gone high produces a pulse.
- R8: After a detection the matcher is back in search with no progress kept. A continuing recessive bus produces no further pulse, and a new complete pattern produces a new pulse.
- R9: A cycle is dominant only when `bus_dom`=1 and `bus_rec`=0, and recessive only when `bus_rec`=1 and `bus_dom`=0. Both high or both low counts as neither, and so acts as an interruption of any phase.
- R10: Asserting `rst_n` low in the middle of a pattern discards all progress; phases seen before the reset do not count toward a later detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Low-power mode active; allows the wake pulse |
| bus_dom | input | 1 | Comparator says bus is dominant (Data_0) |
| bus_rec | input | 1 | Comparator says bus is recessive (Idle or Data_1) |
| wake | output | 1 | One-cycle wakeup-detected pulse |

## Verification
The only result is the registered `wake` output. It is due one cycle after the clock edge that samples the completing input cycle, and it is never combinational. The bench drives inputs on the falling edge and steps a behavioural reference model on the rising edge, from the same sampled inputs. It compares `wake` with the model on the next falling edge, once every cycle. Directed checks count pulses over each scenario. One of them measures that the pulse arrives exactly `IDLE_CYC` cycles after the final recessive phase begins. Window cases placed one cycle on either side of `WIN_CYC` pin down the timeout boundary.

// File: rtl/bus_wake_matcher.sv
module bus_wake_matcher #(
  parameter int D0_CYC   = 400,
  parameter int IDLE_CYC = 400,
  parameter int INT_CYC  = 60,
  parameter int WIN_CYC  = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bus_dom,
  input  logic bus_rec,
  output logic wake
);

  localparam int TMAX = (D0_CYC > IDLE_CYC) ? D0_CYC : IDLE_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int GW   = $clog2(INT_CYC + 1);
  localparam int WW   = $clog2(WIN_CYC + 1);

  logic [1:0]    ph;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;
  logic [WW-1:0] win;
  logic          wake_q;

  wire dom     = bus_dom & ~bus_rec;
  wire rec     = bus_rec & ~bus_dom;
  wire match   = ph[0] ? rec : dom;
  wire busy    = (ph != 2'd0) || (cnt != '0);
  wire [CW-1:0] thr = ph[0] ? CW'(IDLE_CYC) : CW'(D0_CYC);
  wire qual    = cnt >= thr;
  wire gap_end = gap == GW'(INT_CYC - 1);
  wire win_out = win >= WW'(WIN_CYC);
  wire done    = (ph == 2'd3) && match && (cnt >= thr - CW'(1));

  assign wake = wake_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; cnt <= '0; gap <= '0; win <= '0; wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (busy && win_out) begin
        ph <= '0; cnt <= '0; gap <= '0; win <= '0;
      end else if (busy && done) begin
        wake_q <= en;
        ph <= '0; cnt <= '0; gap <= '0; win <= '0;
      end else if (!busy) begin
        if (dom) begin
          cnt <= CW'(1);
          win <= WW'(1);
        end
      end else begin
        win <= win + WW'(1);
        if (match) begin
          gap <= '0;
          if (!qual) cnt <= cnt + CW'(1);
        end else if (gap_end) begin
          gap <= '0;
          if (qual && ph != 2'd3) begin
            ph  <= ph + 2'd1;
            cnt <= CW'(INT_CYC);
          end else begin
            ph <= '0; cnt <= '0; win <= '0;
          end
        end else begin
          gap <= gap + GW'(1);
        end
      end
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(en));
  a_r2_ends_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(rec));
  a_r5_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(win) < WW'(WIN_CYC));
  a_r4_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gap < GW'(INT_CYC));
  a_r8_back_to_search: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (ph == 2'd0 && cnt == '0 && win == '0));

endmodule

// File: tb/bus_wake_matcher_tb_top.sv
`timescale 1ns/100ps
module bus_wake_matcher_tb_top;
  localparam int D0   = 40;
  localparam int IDL  = 40;
  localparam int INTR = 6;
  localparam int WIN  = 400;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, d0_i = 1'b0, r_i = 1'b1;
  logic wake;
  int checks = 0, errors = 0, cyc = 0, pulses = 0, wake_cyc = 0;
  bit exp_wake = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_wake_matcher #(.D0_CYC(D0), .IDLE_CYC(IDL), .INT_CYC(INTR), .WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .bus_dom(d0_i), .bus_rec(r_i), .wake(wake));

  // behavioural reference: phase index, run length, interruption run, elapsed window
  int mp = 0, mc = 0, mg = 0, mwin = 0;
  always @(posedge clk) begin
    bit md, mr, mm, act;
    int mt;
    cyc++;
    exp_wake = 0;
    if (!rst_n) begin
      mp = 0; mc = 0; mg = 0; mwin = 0;
    end else begin
      md  = d0_i && !r_i;
      mr  = r_i && !d0_i;
      mt  = (mp % 2) ? IDL : D0;
      mm  = (mp % 2) ? mr : md;
      act = (mp != 0) || (mc != 0);
      if (act && mwin >= WIN) begin
        mp = 0; mc = 0; mg = 0; mwin = 0;
      end else if (act && mp == 3 && mm && mc + 1 >= mt) begin
        exp_wake = en;
        mp = 0; mc = 0; mg = 0; mwin = 0;
      end else if (!act) begin
        if (md) begin mc = 1; mwin = 1; end
      end else begin
        mwin++;
        if (mm) begin
          mg = 0;
          if (mc < mt) mc++;
        end else begin
          mg++;
          if (mg == INTR) begin
            mg = 0;
            if (mc >= mt && mp < 3) begin mp++; mc = INTR; end
            else begin mp = 0; mc = 0; mwin = 0; end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (wake !== exp_wake) begin
        errors++;
        $display("FAIL R2 cycle %0d model compare: wake=%0b expected=%0b", cyc, wake, exp_wake);
      end
      if (wake === 1'b1) begin pulses++; wake_cyc = cyc; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input bit d, input bit r, input int n);
    d0_i = d; r_i = r;
    repeat (n) @(negedge clk);
  endtask

  task automatic gap_idle();
    hold(0, 1, 500);
    pulses = 0;
  endtask

  task automatic pattern(input int a, input int b, input int c, input int e);
    hold(1, 0, a); hold(0, 1, b); hold(1, 0, c); hold(0, 1, e);
  endtask

  initial begin
    int start;
    repeat (3) @(negedge clk);
    chk("R1 wake low in reset", int'(wake), 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    chk("R1 wake low after reset", int'(wake), 0);
    hold(0, 1, 100);
    chk("R1 idle bus gives no pulse", pulses, 0);
    gap_idle();

    // R2 basic pattern and latency
    hold(1, 0, 50); hold(0, 1, 50); hold(1, 0, 50);
    start = cyc;
    hold(0, 1, 60);
    chk("R2 basic pattern pulse count", pulses, 1);
    chk("R2 pulse latency", wake_cyc - start, IDL);
    gap_idle();

    // R3 short first dominant, short separator
    pattern(30, 50, 50, 50);
    chk("R3 short dominant rejected", pulses, 0);
    gap_idle();
    pattern(50, 20, 50, 50);
    chk("R3 short separator rejected", pulses, 0);
    gap_idle();

    // R4 short interruption tolerated, long one breaks
    hold(1, 0, 20); hold(0, 1, 3); hold(1, 0, 30);
    hold(0, 1, 50); hold(1, 0, 50); hold(0, 1, 50);
    chk("R4 short glitch tolerated", pulses, 1);
    gap_idle();
    hold(1, 0, 25); hold(0, 1, 10); hold(1, 0, 25);
    hold(0, 1, 50); hold(1, 0, 50); hold(0, 1, 50);
    chk("R4 long interruption breaks phase", pulses, 0);
    gap_idle();

    // R9 neutral encodings act as interruptions only
    hold(1, 0, 20); hold(1, 1, 3); hold(1, 0, 30);
    hold(0, 1, 50); hold(1, 0, 20); hold(0, 0, 3); hold(1, 0, 30); hold(0, 1, 50);
    chk("R9 neutral cycles tolerated", pulses, 1);
    gap_idle();
    hold(1, 0, 50); hold(1, 1, 60); hold(1, 0, 50); hold(0, 1, 50);
    chk("R9 both-high is not recessive", pulses, 0);
    gap_idle();

    // R5 window boundary: 400 cycles passes, 401 fails
    pattern(50, 260, 50, 45);
    chk("R5 completes on last window cycle", pulses, 1);
    gap_idle();
    pattern(50, 261, 50, 45);
    chk("R5 one cycle over window", pulses, 0);
    gap_idle();

    // R6 enable low throughout
    en = 1'b0;
    pattern(50, 50, 50, 50);
    chk("R6 no pulse with enable low", pulses, 0);
    gap_idle();

    // R7 begins with enable low, ends with enable high
    hold(1, 0, 50); hold(0, 1, 50); hold(1, 0, 50);
    en = 1'b1;
    hold(0, 1, 50);
    chk("R7 pattern spanning enable rise", pulses, 1);
    gap_idle();

    // R8 back-to-back detections, then silence
    pattern(50, 50, 50, 50);
    pattern(50, 50, 50, 50);
    hold(0, 1, 300);
    chk("R8 two patterns two pulses", pulses, 2);
    gap_idle();

    // R10 reset mid-pattern
    hold(1, 0, 50); hold(0, 1, 50); hold(1, 0, 30);
    rst_n = 1'b0;
    hold(1, 0, 2);
    rst_n = 1'b1;
    hold(1, 0, 20); hold(0, 1, 50);
    chk("R10 reset discards progress", pulses, 0);
    gap_idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule